// File: doc/BRIEF.md
# Standby Controller with Settling Countdown

This block decides what happens when the processor asks to stop. It holds a small control byte. One bit of that byte picks the low-power mode that a sleep request enters. In the light mode, sleep, an interrupt resumes execution one clock later. In the deep mode, standby, the clock source is assumed to be stopped. An external interrupt therefore starts a countdown first, and that countdown keeps the processor and its peripherals held in reset until the oscillator has had time to settle. A three-bit code selects the length of the countdown from a fixed, non-monotonic set of lengths.

While the block is in standby, it also sets what the external bus drives. One policy floats the address lines and the control strobes. The other keeps the last address on the bus and drives every strobe inactive-high. The standby enable bit is not cleared by an interrupt wake-up, so a later sleep request goes straight back into standby. Only a software write of 0 clears it.

The state machine has four states. `PD_RUN` moves to `PD_SLEEP` on a sleep request when the enable bit is 0, and to `PD_STANDBY` when it is 1. `PD_SLEEP` moves to `PD_RUN` on an interrupt. `PD_STANDBY` moves to `PD_SETTLE` on an interrupt, and the countdown is loaded on that same edge. `PD_SETTLE` moves to `PD_RUN` after the last countdown cycle. The `SETTLE_SHIFT` parameter divides every wait by 2^SETTLE_SHIFT so that a small configuration can be tested. Its default of 0 gives the full lengths.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, no mode output or hold is asserted, and the bus passes through with both enables high.
- R2: With byte bit 7 = 0, a sleep request in run mode enters sleep (`in_sleep`=1). An `ext_irq` during sleep returns to run on the next clock, and `settle_hold` is never asserted.
- R3: With byte bit 7 = 1, a sleep request in run mode enters standby (`in_standby`=1). An `ext_irq` during standby asserts `settle_hold` for exactly W consecutive cycles, starting the cycle after the interrupt edge. After those cycles the block is back in run.
- R4: Select codes in bits 6:4 give W = 2^(13+code) >> SETTLE_SHIFT for codes 000 through 101 (8192 through 262144 states when unscaled).
- R5: Code 110 gives W = 1024 >> SETTLE_SHIFT. Code 111 gives the longest wait, 262144 >> SETTLE_SHIFT, and writing it sets bit 0 of `cfg_rdata`. That bit stays set until reset.
- R6: `wake_ready` is high for exactly one cycle, the last cycle in which `settle_hold` is high.
- R7: Bit 7 reads 1 after a standby wake-up, and the next sleep request enters standby again. Writing bit 7 = 0 clears it, and a sleep request then enters sleep.
- R8: In standby with bit 1 = 0, `addr_oe` and `strobe_oe` are low (address and strobes high-impedance).
- R9: In standby with bit 1 = 1, both enables are high, `addr_out` holds the address present on the edge that entered standby, and `strobe_out` is all ones.
- R10: A register write during the countdown does not change the length of the wait already in progress.
- R11: `ext_irq` in run mode has no effect. The block stays in run with no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Write data: [7] standby enable, [6:4] settle code, [1] bus hold enable |
| cfg_rdata | output | 8 | Read data: same fields, plus [0] sticky illegal-code flag |
| sleep_req | input | 1 | Sleep request from the processor |
| ext_irq | input | 1 | External interrupt (wake source) |
| addr_in | input | ADDR_W | Address from the bus master |
| strobe_in | input | STB_W | Control strobes from the bus master |
| addr_out | output | ADDR_W | Address toward the pads |
| addr_oe | output | 1 | Address output enable |
| strobe_out | output | STB_W | Strobes toward the pads |
| strobe_oe | output | 1 | Strobe output enable |
| in_sleep | output | 1 | Sleep mode active |
| in_standby | output | 1 | Standby mode active |
| settle_hold | output | 1 | Processor and peripherals held in reset during the countdown |
| wake_ready | output | 1 | One-cycle pulse on the last countdown cycle |

## Verification
The assertions check on every cycle the rules that do not depend on a count. These are: the bus policy in standby, the one-cycle sleep exit, that the hold starts only after an interrupt in standby, the single-cycle ready pulse, the sticky illegal flag, and that the enable bit falls only after a write of 0. The bench's scenarios are needed for the rest. They show the exact length of every countdown from the coded table, the unchanged wait after a mid-countdown write, and the repeated entry into standby after a wake-up.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    typedef enum logic [1:0] {
        PD_RUN,
        PD_SLEEP,
        PD_STANDBY,
        PD_SETTLE
    } pd_state_e;

    // log2 of the longest wait; sets the counter width
    localparam int SETTLE_MAX_EXP = 18;

    localparam int CFG_SBY_BIT = 7;
    localparam int CFG_SEL_LSB = 4;
    localparam int CFG_OE_BIT  = 1;
    localparam int CFG_ERR_BIT = 0;

    // log2 of the settle wait for a select code; 111 falls back to the longest
    function automatic int settle_exp(input logic [2:0] code);
        int e;
        case (code)
            3'd6:    e = 10;
            3'd7:    e = SETTLE_MAX_EXP;
            default: e = 13 + int'(code);
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwrdn_cfg_reg.sv
module pwrdn_cfg_reg
    import pwrdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic       sby_en,
    output logic [2:0] settle_sel,
    output logic       hold_oe,
    output logic       bad_code
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sby_en     <= 1'b0;
            settle_sel <= 3'd0;
            hold_oe    <= 1'b0;
            bad_code   <= 1'b0;
        end else if (we) begin
            sby_en     <= wdata[CFG_SBY_BIT];
            settle_sel <= wdata[CFG_SEL_LSB +: 3];
            hold_oe    <= wdata[CFG_OE_BIT];
            if (wdata[CFG_SEL_LSB +: 3] == 3'b111) begin
                bad_code <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwrdn_settle_timer.sv
module pwrdn_settle_timer
    import pwrdn_pkg::*;
#(
    parameter int SETTLE_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       dec,
    input  logic [2:0] sel,
    output logic       zero
);

    localparam int CNT_W = SETTLE_MAX_EXP - SETTLE_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    int               sh;

    // Wait of W states: load W-1, so the count spans W cycles
    always_comb begin
        sh = settle_exp(sel) - SETTLE_SHIFT;
        if (sh < 0) begin
            sh = 0;
        end
        load_val = CNT_W'((64'd1 << sh) - 64'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pwrdn_bus_policy.sv
module pwrdn_bus_policy #(
    parameter int ADDR_W = 24,
    parameter int STB_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              hold_oe,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [STB_W-1:0]  strobe_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [STB_W-1:0]  strobe_out,
    output logic              strobe_oe
);

    logic [ADDR_W-1:0] addr_hold_q;

    // Track the live address until standby begins, then freeze it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold_q <= '0;
        end else if (!standby) begin
            addr_hold_q <= addr_in;
        end
    end

    always_comb begin
        addr_out   = addr_in;
        strobe_out = strobe_in;
        addr_oe    = 1'b1;
        strobe_oe  = 1'b1;
        if (standby) begin
            if (hold_oe) begin
                addr_out   = addr_hold_q;
                strobe_out = '1;
            end else begin
                addr_oe    = 1'b0;
                strobe_oe  = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int STB_W        = 8,
    parameter int SETTLE_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              sleep_req,
    input  logic              ext_irq,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [STB_W-1:0]  strobe_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [STB_W-1:0]  strobe_out,
    output logic              strobe_oe,
    output logic              in_sleep,
    output logic              in_standby,
    output logic              settle_hold,
    output logic              wake_ready
);

    pd_state_e  state_q, state_d;
    logic       sby_en, hold_oe, bad_code;
    logic [2:0] settle_sel;
    logic       timer_load, timer_dec, timer_zero;

    pwrdn_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .sby_en     (sby_en),
        .settle_sel (settle_sel),
        .hold_oe    (hold_oe),
        .bad_code   (bad_code)
    );

    always_comb begin
        cfg_rdata                      = '0;
        cfg_rdata[CFG_SBY_BIT]         = sby_en;
        cfg_rdata[CFG_SEL_LSB +: 3]    = settle_sel;
        cfg_rdata[CFG_OE_BIT]          = hold_oe;
        cfg_rdata[CFG_ERR_BIT]         = bad_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PD_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_RUN:     if (sleep_req)  state_d = sby_en ? PD_STANDBY : PD_SLEEP;
            PD_SLEEP:   if (ext_irq)    state_d = PD_RUN;
            PD_STANDBY: if (ext_irq)    state_d = PD_SETTLE;
            PD_SETTLE:  if (timer_zero) state_d = PD_RUN;
            default:                    state_d = PD_RUN;
        endcase
    end

    always_comb begin
        in_sleep    = 1'b0;
        in_standby  = 1'b0;
        settle_hold = 1'b0;
        wake_ready  = 1'b0;
        timer_load  = 1'b0;
        timer_dec   = 1'b0;
        unique case (state_q)
            PD_RUN:     ;
            PD_SLEEP:   in_sleep = 1'b1;
            PD_STANDBY: begin
                in_standby = 1'b1;
                timer_load = ext_irq;
            end
            PD_SETTLE:  begin
                settle_hold = 1'b1;
                timer_dec   = 1'b1;
                wake_ready  = timer_zero;
            end
            default:    ;
        endcase
    end

    pwrdn_settle_timer #(
        .SETTLE_SHIFT (SETTLE_SHIFT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .dec   (timer_dec),
        .sel   (settle_sel),
        .zero  (timer_zero)
    );

    pwrdn_bus_policy #(
        .ADDR_W (ADDR_W),
        .STB_W  (STB_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (in_standby),
        .hold_oe    (hold_oe),
        .addr_in    (addr_in),
        .strobe_in  (strobe_in),
        .addr_out   (addr_out),
        .addr_oe    (addr_oe),
        .strobe_out (strobe_out),
        .strobe_oe  (strobe_oe)
    );

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
    parameter int ADDR_W = 24,
    parameter int STB_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              sleep_req,
    input logic              ext_irq,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_oe,
    input logic [STB_W-1:0]  strobe_out,
    input logic              strobe_oe,
    input logic              in_sleep,
    input logic              in_standby,
    input logic              settle_hold,
    input logic              wake_ready
);

    a_r2_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && ext_irq) |=> (!in_sleep && !in_standby && !settle_hold));

    a_r3_hold_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settle_hold) |-> ($past(in_standby) && $past(ext_irq)));

    a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_hold && !wake_ready) |=> settle_hold);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] |=> cfg_rdata[0]);

    a_r6_ready_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ready |-> settle_hold);

    a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ready |=> (!wake_ready && !settle_hold));

    a_r7_sby_only_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_rdata[7]) |-> ($past(cfg_we) && !$past(cfg_wdata[7])));

    a_r8_float_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && !cfg_rdata[1]) |-> (!addr_oe && !strobe_oe));

    a_r9_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && cfg_rdata[1]) |-> (addr_oe && strobe_oe && (strobe_out == '1)));

    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && $past(in_standby) && cfg_rdata[1]) |-> $stable(addr_out));

    a_r11_run_ignores_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sleep && !in_standby && !settle_hold && !sleep_req)
            |=> (!in_sleep && !in_standby && !settle_hold));

endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .STB_W  (STB_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .sleep_req   (sleep_req),
    .ext_irq     (ext_irq),
    .addr_out    (addr_out),
    .addr_oe     (addr_oe),
    .strobe_out  (strobe_out),
    .strobe_oe   (strobe_oe),
    .in_sleep    (in_sleep),
    .in_standby  (in_standby),
    .settle_hold (settle_hold),
    .wake_ready  (wake_ready)
);

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;

    localparam int AW = 8;
    localparam int SW = 4;
    localparam int SH = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          sleep_req = 1'b0;
    logic          ext_irq = 1'b0;
    logic [AW-1:0] addr_in = 8'h3C;
    logic [SW-1:0] strobe_in = 4'b0101;
    logic [AW-1:0] addr_out;
    logic          addr_oe;
    logic [SW-1:0] strobe_out;
    logic          strobe_oe;
    logic          in_sleep, in_standby, settle_hold, wake_ready;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwrdn_ctrl #(
        .ADDR_W       (AW),
        .STB_W        (SW),
        .SETTLE_SHIFT (SH)
    ) u_pwrdn_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .sleep_req   (sleep_req),
        .ext_irq     (ext_irq),
        .addr_in     (addr_in),
        .strobe_in   (strobe_in),
        .addr_out    (addr_out),
        .addr_oe     (addr_oe),
        .strobe_out  (strobe_out),
        .strobe_oe   (strobe_oe),
        .in_sleep    (in_sleep),
        .in_standby  (in_standby),
        .settle_hold (settle_hold),
        .wake_ready  (wake_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_wait(input int code);
        int e;
        e = (code < 6) ? 13 + code : ((code == 6) ? 10 : 18);
        return 1 << (e - SH);
    endfunction

    task automatic wr(input bit sby, input int code, input bit oe);
        @(negedge clk);
        cfg_wdata = {sby, 3'(code), 2'b00, oe, 1'b0};
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Enter standby, check the bus, wake, and measure the hold length.
    // If mid_code >= 0, a write of that code lands during the countdown.
    task automatic standby_cycle(input int code, input bit oe, input int mid_code);
        int  cnt;
        int  ready_n;
        int  ready_at;
        addr_in = 8'hA5;
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        addr_in   = 8'h5A;
        chk(in_standby == 1'b1, "R3", int'(in_standby), 1);
        if (oe) begin
            chk(addr_oe && addr_out == 8'hA5, "R9", int'(addr_out), 8'hA5);
            chk(strobe_oe && strobe_out == 4'hF, "R9", int'(strobe_out), 15);
        end else begin
            chk(!addr_oe && !strobe_oe, "R8", int'({addr_oe, strobe_oe}), 0);
        end
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq  = 1'b0;
        cnt      = 0;
        ready_n  = 0;
        ready_at = -1;
        while (settle_hold && cnt < 10000) begin
            cnt++;
            if (wake_ready) begin
                ready_n++;
                ready_at = cnt;
            end
            if (mid_code >= 0 && cnt == 5) begin
                cfg_wdata = {1'b1, 3'(mid_code), 2'b00, oe, 1'b0};
                cfg_we    = 1'b1;
            end else begin
                cfg_we    = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        if (mid_code >= 0) begin
            chk(cnt == exp_wait(code), "R10", cnt, exp_wait(code));
        end else if (code < 6) begin
            chk(cnt == exp_wait(code), "R4", cnt, exp_wait(code));
        end else begin
            chk(cnt == exp_wait(code), "R5", cnt, exp_wait(code));
        end
        chk(ready_n == 1 && ready_at == cnt, "R6", ready_at, cnt);
        chk(!in_standby && !settle_hold && !in_sleep, "R3", int'(in_standby), 0);
        chk(cfg_rdata[7] == 1'b1, "R7", int'(cfg_rdata[7]), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 8'h00, "R1", int'(cfg_rdata), 0);
        chk(!in_sleep && !in_standby && !settle_hold && !wake_ready, "R1",
            int'({in_sleep, in_standby, settle_hold, wake_ready}), 0);
        chk(addr_oe && strobe_oe && addr_out == addr_in && strobe_out == strobe_in,
            "R1", int'(addr_out), int'(addr_in));

        // R11 interrupt in run mode
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        @(negedge clk);
        chk(!in_sleep && !in_standby && !settle_hold, "R11",
            int'({in_sleep, in_standby, settle_hold}), 0);

        // R2 sleep and one-clock resume
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(in_sleep && !in_standby, "R2", int'(in_sleep), 1);
        repeat (3) @(negedge clk);
        chk(in_sleep, "R2", int'(in_sleep), 1);
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        chk(!in_sleep && !settle_hold, "R2", int'({in_sleep, settle_hold}), 0);

        // R4, R5: sweep every select code, alternating bus policy
        for (int c = 0; c < 8; c++) begin
            wr(1'b1, c, c[0]);
            chk(cfg_rdata[0] == (c == 7), "R5", int'(cfg_rdata[0]), int'(c == 7));
            standby_cycle(c, c[0], -1);
        end

        // R7: enable bit still set, so the next request enters standby again
        wr(1'b1, 6, 1'b1);
        standby_cycle(6, 1'b1, -1);
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(in_standby, "R7", int'(in_standby), 1);
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        while (settle_hold) @(negedge clk);
        wr(1'b0, 6, 1'b1);
        chk(cfg_rdata[7] == 1'b0, "R7", int'(cfg_rdata[7]), 0);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(in_sleep && !in_standby, "R7", int'(in_sleep), 1);
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        chk(cfg_rdata[0] == 1'b1, "R5", int'(cfg_rdata[0]), 1);

        // R10: long wait, rewrite to the short code during the countdown
        wr(1'b1, 1, 1'b1);
        standby_cycle(1, 1'b1, 6);
        // and short wait, rewrite to the long code
        wr(1'b1, 6, 1'b0);
        standby_cycle(6, 1'b0, 5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule